// File: doc/BRIEF.md
# Toggle-Bit Completion Polling Controller

This block runs on the host side of a flash memory. It decides when a program or erase operation has finished by polling the device status word. After a start pulse it reads the status twice and compares one toggle bit between the two reads. Bit 6 is compared when `bit_sel_i` is 0 at start, and bit 2 when it is 1. If the bit held still, the operation is over and `done_o` pulses. If the bit moved, the controller looks at the timeout flag in bit 5 of the second read. A clear flag means the device is still working, so another pair of reads follows. A set flag triggers one fresh pair of reads as a recheck, because toggling can stop at the same moment the flag rises. If the recheck pair still toggles, the controller writes the reset command 0xF0 to the device and pulses `fail_o`.

The host may park the poll to do other work and restart it later. Polling always resumes from the first read of a fresh pair, and any pending recheck is forgotten. Reads and the reset write leave on a single request channel with valid/ready handshaking. Once `req_valid_o` is high, the request and its write flag and data stay fixed until `req_ready_i` is seen high on a clock edge. Back-pressure only stalls the controller. Only one read is in flight at a time. The controller issues no new request until the response for the current read returns, as a one-cycle `rsp_valid_i` with `rsp_data_i`.

Top module: `tog_poll_ctrl`

## Requirements
- R1: After `start_i` is accepted while idle, the controller issues status reads (`req_write_o`=0) as one pair: a read request is followed by its response before the next request is raised.
- R2: If the selected toggle bit is equal in both reads of a pair, `done_o` is high for one cycle in the cycle after the second response, and no further request is issued.
- R3: If the selected bit differs and bit 5 of the second read is 0, another pair of reads follows without any `done_o` or `fail_o`.
- R4: If the selected bit differs and bit 5 of the second read is 1, a fresh recheck pair follows. If that pair shows no toggle, the result is `done_o`.
- R5: If the recheck pair still toggles, a write request (`req_write_o`=1, `req_wdata_o`=0xF0) is raised. `fail_o` is high for one cycle in the cycle after that write is accepted.
- R6: A `park_i` pulse seen during polling takes effect at the next read response. That response is discarded, no requests are raised while parked, and `busy_o` stays high.
- R7: A `resume_i` pulse while parked restarts polling at the first read of a new pair, with any pending recheck cleared.
- R8: `busy_o` rises in the cycle after an accepted start and falls in the cycle where `done_o` or `fail_o` is high. The two result pulses last one cycle each. `start_i` is ignored while busy.
- R9: While `req_valid_o` is high and `req_ready_i` is low, the request, its write flag and its data stay unchanged.
- R10: The bit selection is latched at start. Bit 6 is the toggle bit when `bit_sel_i`=0, and bit 2 when it is 1. The unselected bit has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a poll (one cycle) |
| bit_sel_i | input | 1 | Toggle bit choice: 0 = bit 6, 1 = bit 2 |
| park_i | input | 1 | Request to park the poll |
| resume_i | input | 1 | Restart a parked poll |
| req_valid_o | output | 1 | Bus request valid |
| req_ready_i | input | 1 | Bus request accepted |
| req_write_o | output | 1 | 1 = write, 0 = status read |
| req_wdata_o | output | 8 | Write data |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 8 | Status word returned |
| done_o | output | 1 | Success pulse |
| fail_o | output | 1 | Failure pulse |
| busy_o | output | 1 | Poll in progress |

## Verification
The hardest situation to reach from the ports is a park that lands in the middle of a recheck pair, followed by a resume whose first new pair toggles with the timeout flag clear. Only a correctly cleared recheck state keeps that case from ending in a failure. The bench reaches it by feeding a status sequence that sets the flag on the first pair. It raises `park_i` exactly when the recheck read is being requested, and after the resume it supplies a toggling pair without the flag and then a quiet pair. Slow `req_ready_i` patterns are mixed in so that requests and the reset write are held under back-pressure.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RA   = 3'd1,
    ST_WA   = 3'd2,
    ST_RB   = 3'd3,
    ST_WB   = 3'd4,
    ST_RST  = 3'd5,
    ST_PARK = 3'd6
  } poll_st_t;
endpackage

// File: rtl/tbp_cmp.sv
module tbp_cmp #(
  parameter int DW      = 8,
  parameter int BIT_HI  = 6,
  parameter int BIT_LO  = 2,
  parameter int TMO_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_load,
  input  logic          sel_in,
  input  logic          cap_en,
  input  logic [DW-1:0] data,
  output logic          toggled,
  output logic          timeout
);
  logic sel_q;
  logic first_q;
  logic cur_bit;

  // pick the watched bit from the latched selection
  assign cur_bit = sel_q ? data[BIT_LO] : data[BIT_HI];
  assign toggled = first_q ^ cur_bit;
  assign timeout = data[TMO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (sel_load) sel_q <= sel_in;
      if (cap_en) first_q <= cur_bit;
    end
  end
endmodule

// File: rtl/tbp_fsm.sv
module tbp_fsm
  import tbp_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] RST_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          park_i,
  input  logic          resume_i,
  input  logic          req_ready_i,
  input  logic          rsp_valid_i,
  input  logic          toggled,
  input  logic          timeout,
  output logic          sel_load,
  output logic          cap_en,
  output logic          req_valid_o,
  output logic          req_write_o,
  output logic [DW-1:0] req_wdata_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          busy_o
);
  poll_st_t st_q;
  logic     recheck_q;
  logic     pend_q;
  logic     park_now;

  assign park_now    = pend_q | park_i;
  assign sel_load    = (st_q == ST_IDLE) && start_i;
  assign cap_en      = (st_q == ST_WA) && rsp_valid_i;
  assign req_valid_o = (st_q == ST_RA) || (st_q == ST_RB) || (st_q == ST_RST);
  assign req_write_o = (st_q == ST_RST);
  assign req_wdata_o = (st_q == ST_RST) ? RST_CMD : '0;
  assign busy_o      = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      recheck_q <= 1'b0;
      pend_q    <= 1'b0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (start_i) begin
            st_q      <= ST_RA;
            recheck_q <= 1'b0;
          end
        end
        ST_RA, ST_RB: begin
          if (park_i) pend_q <= 1'b1;
          if (req_ready_i) st_q <= (st_q == ST_RA) ? ST_WA : ST_WB;
        end
        ST_WA: begin
          if (rsp_valid_i) begin
            if (park_now) begin
              st_q   <= ST_PARK;
              pend_q <= 1'b0;
            end else begin
              st_q <= ST_RB;
            end
          end else if (park_i) begin
            pend_q <= 1'b1;
          end
        end
        ST_WB: begin
          if (rsp_valid_i) begin
            if (park_now) begin
              st_q   <= ST_PARK;
              pend_q <= 1'b0;
            end else if (!toggled) begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
            end else if (recheck_q) begin
              st_q <= ST_RST;
            end else begin
              st_q <= ST_RA;
              if (timeout) recheck_q <= 1'b1;
            end
          end else if (park_i) begin
            pend_q <= 1'b1;
          end
        end
        ST_RST: begin
          if (req_ready_i) begin
            st_q   <= ST_IDLE;
            fail_o <= 1'b1;
          end
        end
        ST_PARK: begin
          if (resume_i) begin
            st_q      <= ST_RA;
            recheck_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_write_o) && $stable(req_wdata_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o); // R8
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> !busy_o); // R8
  AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> $past(req_valid_o && req_write_o && req_ready_i)); // R5
  AST_DONE_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rsp_valid_i)); // R2
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK) && !resume_i |=> (st_q == ST_PARK) && !req_valid_o); // R6
endmodule

// File: rtl/tog_poll_ctrl.sv
module tog_poll_ctrl #(
  parameter int            DW      = 8,
  parameter int            BIT_HI  = 6,
  parameter int            BIT_LO  = 2,
  parameter int            TMO_BIT = 5,
  parameter logic [DW-1:0] RST_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          bit_sel_i,
  input  logic          park_i,
  input  logic          resume_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          done_o,
  output logic          fail_o,
  output logic          busy_o
);
  logic sel_load;
  logic cap_en;
  logic toggled;
  logic timeout;

  tbp_cmp #(.DW(DW), .BIT_HI(BIT_HI), .BIT_LO(BIT_LO), .TMO_BIT(TMO_BIT)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_load (sel_load),
    .sel_in   (bit_sel_i),
    .cap_en   (cap_en),
    .data     (rsp_data_i),
    .toggled  (toggled),
    .timeout  (timeout)
  );

  tbp_fsm #(.DW(DW), .RST_CMD(RST_CMD)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .park_i      (park_i),
    .resume_i    (resume_i),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .toggled     (toggled),
    .timeout     (timeout),
    .sel_load    (sel_load),
    .cap_en      (cap_en),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_wdata_o (req_wdata_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .busy_o      (busy_o)
  );
endmodule

// File: tb/tog_poll_ctrl_tb.sv
module tog_poll_ctrl_tb;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start_i, bit_sel_i, park_i, resume_i;
  logic req_valid_o, req_ready_i, req_write_o;
  logic [7:0] req_wdata_o;
  logic rsp_valid_i;
  logic [7:0] rsp_data_i;
  logic done_o, fail_o, busy_o;

  tog_poll_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_sel_i(bit_sel_i),
    .park_i(park_i), .resume_i(resume_i), .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i), .req_write_o(req_write_o), .req_wdata_o(req_wdata_o),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .done_o(done_o),
    .fail_o(fail_o), .busy_o(busy_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, rsp_wait = 0;
  int n_done = 0, n_fail = 0;
  logic [7:0] stq[$];
  logic nx_start = 0, nx_park = 0, nx_resume = 0, slow = 0;
  // reference model: 0 idle,1 read A,2 wait A,3 read B,4 wait B,5 reset write,6 parked
  int m_st = 0;
  logic m_pend = 0, m_rech = 0, m_b1 = 0, m_sel = 0, m_done = 0, m_fail = 0;

  task automatic chk(input logic c, input string req, input int act, input int exp);
    n_cmp++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic pick(input logic s, input logic [7:0] d);
    return s ? d[2] : d[6];
  endfunction

  task automatic step_cycle();
    logic mv, tog;
    @(negedge clk);
    cyc++;
    mv = (m_st == 1) || (m_st == 3) || (m_st == 5);
    if (rst_n) begin
      chk(busy_o == (m_st != 0), "R8 busy", busy_o, m_st != 0);
      chk(req_valid_o == mv, "R1 req_valid", req_valid_o, mv);
      chk(req_write_o == (m_st == 5), "R5 req_write", req_write_o, m_st == 5);
      if (m_st == 5) chk(req_wdata_o == 8'hF0, "R5 write data", req_wdata_o, 8'hF0);
      chk(done_o == m_done, "R2 done", done_o, m_done);
      chk(fail_o == m_fail, "R5 fail", fail_o, m_fail);
      if (done_o) n_done++;
      if (fail_o) n_fail++;
    end
    start_i = nx_start; park_i = nx_park; resume_i = nx_resume;
    nx_start = 0; nx_park = 0; nx_resume = 0;
    req_ready_i = slow ? (cyc % 3 == 0) : 1'b1;
    rsp_valid_i = 1'b0;
    if (rsp_wait > 0) begin
      rsp_wait--;
      if (rsp_wait == 0) begin
        rsp_valid_i = 1'b1;
        rsp_data_i = (stq.size() > 0) ? stq.pop_front() : 8'h00;
      end
    end
    m_done = 0; m_fail = 0;
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_rech = 0; m_b1 = 0; m_sel = 0;
    end else begin
      case (m_st)
        0: begin m_pend = 0; if (start_i) begin m_st = 1; m_rech = 0; m_sel = bit_sel_i; end end
        1, 3: begin
          if (park_i) m_pend = 1;
          if (req_ready_i) begin rsp_wait = LAT; m_st = m_st + 1; end
        end
        2, 4: begin
          if (rsp_valid_i) begin
            tog = m_b1 ^ pick(m_sel, rsp_data_i);
            if (m_pend || park_i) begin m_st = 6; m_pend = 0; end
            else if (m_st == 2) begin m_b1 = pick(m_sel, rsp_data_i); m_st = 3; end
            else if (!tog) begin m_st = 0; m_done = 1; end
            else if (m_rech) m_st = 5;
            else begin m_st = 1; if (rsp_data_i[5]) m_rech = 1; end
          end else if (park_i) m_pend = 1;
          if (m_st == 2 && rsp_valid_i) m_b1 = pick(m_sel, rsp_data_i);
        end
        5: if (req_ready_i) begin m_st = 0; m_fail = 1; end
        6: if (resume_i) begin m_st = 1; m_rech = 0; end
        default: m_st = 0;
      endcase
    end
  endtask

  task automatic run_op(input logic sel, input int exp_d, input int exp_f, input string req);
    int d0, f0;
    d0 = n_done; f0 = n_fail;
    bit_sel_i = sel; nx_start = 1;
    step_cycle();
    for (int i = 0; i < 500 && m_st != 0; i++) begin
      if (i == 3) nx_start = 1; // start while busy is ignored (R8)
      step_cycle();
    end
    step_cycle();
    step_cycle();
    chk(n_done - d0 == exp_d, {req, " done count"}, n_done - d0, exp_d);
    chk(n_fail - f0 == exp_f, {req, " fail count"}, n_fail - f0, exp_f);
    chk(stq.size() == 0, {req, " status words consumed"}, stq.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; start_i = 0; bit_sel_i = 0; park_i = 0; resume_i = 0;
    req_ready_i = 0; rsp_valid_i = 0; rsp_data_i = 0;
    repeat (3) step_cycle();
    rst_n = 1;
    step_cycle();
    chk(!busy_o && !req_valid_o && !done_o && !fail_o, "R8 reset state",
        {busy_o, req_valid_o, done_o, fail_o}, 0);

    // R2: quiet pair on bit 6
    stq = '{8'h40, 8'h40};
    run_op(0, 1, 0, "R2");
    // R3: toggling pair with timeout clear, then quiet pair
    stq = '{8'h40, 8'h00, 8'h00, 8'h00};
    run_op(0, 1, 0, "R3");
    // R4: timeout seen, recheck pair quiet
    stq = '{8'h40, 8'h20, 8'h20, 8'h20};
    run_op(0, 1, 0, "R4");
    // R5: timeout seen, recheck still toggles, under back-pressure (R9)
    slow = 1;
    stq = '{8'h40, 8'h20, 8'h00, 8'h40};
    run_op(0, 0, 1, "R5");
    // R10: bit 2 chosen, bit 6 moves but is ignored
    stq = '{8'h40, 8'h00};
    run_op(1, 1, 0, "R10");
    // R10: bit 2 chosen and toggling, then quiet
    stq = '{8'h04, 8'h00, 8'h04, 8'h04};
    run_op(1, 1, 0, "R10 toggle");
    slow = 0;

    // R6/R7: park during the recheck pair, resume with toggle and flag clear
    begin
      int d0, f0;
      d0 = n_done; f0 = n_fail;
      stq = '{8'h40, 8'h20, 8'h20, 8'h00, 8'h40, 8'h00, 8'h00};
      bit_sel_i = 0; nx_start = 1;
      step_cycle();
      for (int i = 0; i < 200 && !(m_st == 1 && m_rech); i++) step_cycle();
      nx_park = 1;
      for (int i = 0; i < 200 && m_st != 6; i++) step_cycle();
      repeat (6) step_cycle();
      chk(busy_o && !req_valid_o, "R6 parked quiet and busy", {busy_o, req_valid_o}, 2);
      nx_resume = 1;
      step_cycle();
      step_cycle();
      chk(req_valid_o && !req_write_o, "R7 restart read", {req_valid_o, req_write_o}, 2);
      for (int i = 0; i < 500 && m_st != 0; i++) step_cycle();
      repeat (2) step_cycle();
      chk(n_done - d0 == 1, "R7 done after resume", n_done - d0, 1);
      chk(n_fail - f0 == 0, "R7 no fail after resume", n_fail - f0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule